// File: doc/BRIEF.md
# Superscalar Operand Bypass Network

This block picks the value that each ALU operand input of an N-wide in-order pipeline should use. Every lane has two operands, so there are 2N operand ports. Each port carries a source register number and the value read from the register file. The block compares that register number against the destination tags of every producer at two pipeline levels: the N instructions now in the execute stage, and the N instructions now in writeback. When a live producer matches, the block forwards that producer's result in place of the register-file value.

Each operand also gets a two-bit code that says where its value came from. The ALUs and the hazard logic can use this code.

The block has two variants, chosen by parameter. In the flat variant (one cluster), any lane can forward to any operand. In the clustered variant, the lanes form K groups. A lane forwards in the same cycle only to operands of its own group. An execute-stage result from another group reaches a consumer a fixed number of cycles later, through a small register pipeline of tags and values. The block holds no other state.

Top module: `opnd_bypass_net`

## Requirements
- R1: After reset the cross-group delay pipeline is empty, so no operand receives a cross-group value until a producer has entered it.
- R2: A producer matches an operand only when its valid bit and its write-enable are both 1, its destination number is nonzero, and that number equals the operand's source number. Source register 0 is never forwarded.
- R3: When a same-group execute-stage producer and a same-group writeback producer both match, the execute-stage result is used.
- R4: When several producers of the same level match, the one in the highest-numbered lane (the youngest in program order) is used.
- R5: Each operand has a code with these values: 0 = register-file value, 1 = execute-stage forward, 2 = writeback forward, 3 = cross-group forward. When nothing matches, the code is 0 and the output equals the register-file input.
- R6: Operands 2l and 2l+1 belong to lane l. Lanes are split into contiguous groups of N/K lanes. In the clustered variant, same-cycle forwarding at either level comes only from lanes of the operand's own group.
- R7: An execute-stage result from a lane of another group, presented in cycle t, is visible to an operand only in cycle t+XDELAY (XDELAY is 1 or 2). It is not visible in any earlier or later cycle.
- R8: Any same-group match, at either level, takes precedence over a cross-group value.
- R9: When several cross-group producers that entered in the same cycle match, the highest-numbered lane wins. A producer whose write-enable was 0 never produces a cross-group forward.
- R10: In the flat variant (CLUSTERS = 1), a producer in any lane forwards in the same cycle to any operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_src | input | 2*LANES*AW | Source register number per operand |
| rf_val | input | 2*LANES*DW | Register-file read value per operand |
| ex_vld | input | LANES | Execute-stage producer valid, per lane |
| ex_wen | input | LANES | Execute-stage producer writes a register |
| ex_dst | input | LANES*AW | Execute-stage destination number |
| ex_res | input | LANES*DW | Execute-stage result |
| wb_vld | input | LANES | Writeback producer valid, per lane |
| wb_wen | input | LANES | Writeback producer writes a register |
| wb_dst | input | LANES*AW | Writeback destination number |
| wb_res | input | LANES*DW | Writeback result |
| op_val | output | 2*LANES*DW | Selected operand value |
| op_kind | output | 2*LANES*2 | Source code per operand (R5) |

## Verification
In one cycle, an operand can see a same-group forward and a cross-group value that has just come out of the delay pipeline. The bench provokes this by loading a remote execute-stage producer. XDELAY cycles later, when that value emerges, it presents a same-group writeback producer with the same destination. The expected result is the writeback value with code 2, and the remote value with code 3 appears once the local producer is withdrawn. The delay window is checked cycle by cycle: before, on and after the cycle in which the remote value emerges. The flat instance receives the same stimulus as a reference. There, the same producer must forward at once.

// File: rtl/opbyp_pkg.sv
package opbyp_pkg;

    typedef enum logic [1:0] {
        SRC_RF = 2'd0,
        SRC_MX = 2'd1,
        SRC_WX = 2'd2,
        SRC_XC = 2'd3
    } opnd_src_e;

    // group index of a lane, lanes are laid out contiguously per group
    function automatic int lane_group(input int lane, input int lanes_per_group);
        return lane / lanes_per_group;
    endfunction

endpackage

// File: rtl/opbyp_pick.sv
module opbyp_pick #(
    parameter int CANDS = 4,
    parameter int DW    = 32,
    parameter int AW    = 5
) (
    input  logic [AW-1:0]       src,
    input  logic [CANDS-1:0]    cand_ok,
    input  logic [CANDS*AW-1:0] cand_dst,
    input  logic [CANDS*DW-1:0] cand_val,
    output logic                hit,
    output logic [DW-1:0]       val
);
    // ascending scan: the last (highest lane, youngest) match overrides
    always_comb begin
        hit = 1'b0;
        val = '0;
        for (int j = 0; j < CANDS; j++) begin
            if (cand_ok[j] && (src != '0) && (cand_dst[j*AW +: AW] == src)) begin
                hit = 1'b1;
                val = cand_val[j*DW +: DW];
            end
        end
    end
endmodule

// File: rtl/opbyp_xdelay.sv
module opbyp_xdelay #(
    parameter int LANES = 4,
    parameter int DW    = 32,
    parameter int AW    = 5,
    parameter int DEPTH = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LANES-1:0]    in_ok,
    input  logic [LANES*AW-1:0] in_dst,
    input  logic [LANES*DW-1:0] in_val,
    output logic [LANES-1:0]    out_ok,
    output logic [LANES*AW-1:0] out_dst,
    output logic [LANES*DW-1:0] out_val
);
    logic [LANES-1:0]    ok_q  [DEPTH];
    logic [LANES*AW-1:0] dst_q [DEPTH];
    logic [LANES*DW-1:0] val_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            ok_q[0] <= '0;
        end else begin
            ok_q[0] <= in_ok;
        end
        dst_q[0] <= in_dst;
        val_q[0] <= in_val;
    end

    for (genvar k = 1; k < DEPTH; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                ok_q[k] <= '0;
            end else begin
                ok_q[k] <= ok_q[k-1];
            end
            dst_q[k] <= dst_q[k-1];
            val_q[k] <= val_q[k-1];
        end
    end

    assign out_ok  = ok_q[DEPTH-1];
    assign out_dst = dst_q[DEPTH-1];
    assign out_val = val_q[DEPTH-1];

    initial begin
        AST_DEPTH_RANGE: assert (DEPTH >= 1 && DEPTH <= 2); // R7
    end

    // edges since reset, saturating at DEPTH
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst < 2'(DEPTH)) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    AST_XC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'(DEPTH)) |-> (out_ok == $past(in_ok, DEPTH))); // R7

    AST_XC_EMPTY_AT_START: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd0) |-> (out_ok == '0)); // R1
endmodule

// File: rtl/opnd_bypass_net.sv
module opnd_bypass_net
    import opbyp_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int CLUSTERS = 2,
    parameter int XDELAY   = 2,
    parameter int DW       = 32,
    parameter int AW       = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [2*LANES*AW-1:0]   op_src,
    input  logic [2*LANES*DW-1:0]   rf_val,
    input  logic [LANES-1:0]        ex_vld,
    input  logic [LANES-1:0]        ex_wen,
    input  logic [LANES*AW-1:0]     ex_dst,
    input  logic [LANES*DW-1:0]     ex_res,
    input  logic [LANES-1:0]        wb_vld,
    input  logic [LANES-1:0]        wb_wen,
    input  logic [LANES*AW-1:0]     wb_dst,
    input  logic [LANES*DW-1:0]     wb_res,
    output logic [2*LANES*DW-1:0]   op_val,
    output logic [2*LANES*2-1:0]    op_kind
);
    localparam int  OPS       = 2 * LANES;
    localparam int  LPG       = LANES / CLUSTERS;
    localparam bit  CLUSTERED = (CLUSTERS > 1);

    logic [LANES-1:0]    ex_ok, wb_ok;
    logic [LANES-1:0]    xc_ok;
    logic [LANES*AW-1:0] xc_dst;
    logic [LANES*DW-1:0] xc_val;

    assign ex_ok = ex_vld & ex_wen;
    assign wb_ok = wb_vld & wb_wen;

    if (CLUSTERED) begin : g_xc
        opbyp_xdelay #(
            .LANES(LANES), .DW(DW), .AW(AW), .DEPTH(XDELAY)
        ) u_xdelay (
            .clk     (clk),
            .rst     (rst),
            .in_ok   (ex_ok),
            .in_dst  (ex_dst),
            .in_val  (ex_res),
            .out_ok  (xc_ok),
            .out_dst (xc_dst),
            .out_val (xc_val)
        );
    end else begin : g_flat
        assign xc_ok  = '0;
        assign xc_dst = '0;
        assign xc_val = '0;
    end

    initial begin
        AST_GROUPS_EVEN: assert (LANES % CLUSTERS == 0); // R6
    end

    for (genvar o = 0; o < OPS; o++) begin : g_op
        localparam int MY_GROUP = lane_group(o / 2, LPG);

        logic [LANES-1:0] local_mask;
        logic [AW-1:0]    src;
        logic [DW-1:0]    rf_in;
        logic             mx_hit, wx_hit, xc_hit;
        logic [DW-1:0]    mx_v, wx_v, xc_v;
        logic [DW-1:0]    sel_val;
        opnd_src_e        sel_kind;

        for (genvar j = 0; j < LANES; j++) begin : g_mask
            assign local_mask[j] = (lane_group(j, LPG) == MY_GROUP);
        end

        assign src   = op_src[o*AW +: AW];
        assign rf_in = rf_val[o*DW +: DW];

        opbyp_pick #(.CANDS(LANES), .DW(DW), .AW(AW)) u_mx (
            .src (src), .cand_ok (ex_ok & local_mask),
            .cand_dst (ex_dst), .cand_val (ex_res),
            .hit (mx_hit), .val (mx_v)
        );
        opbyp_pick #(.CANDS(LANES), .DW(DW), .AW(AW)) u_wx (
            .src (src), .cand_ok (wb_ok & local_mask),
            .cand_dst (wb_dst), .cand_val (wb_res),
            .hit (wx_hit), .val (wx_v)
        );
        opbyp_pick #(.CANDS(LANES), .DW(DW), .AW(AW)) u_xc (
            .src (src), .cand_ok (xc_ok & ~local_mask),
            .cand_dst (xc_dst), .cand_val (xc_val),
            .hit (xc_hit), .val (xc_v)
        );

        always_comb begin
            if (mx_hit) begin
                sel_kind = SRC_MX;
                sel_val  = mx_v;
            end else if (wx_hit) begin
                sel_kind = SRC_WX;
                sel_val  = wx_v;
            end else if (xc_hit) begin
                sel_kind = SRC_XC;
                sel_val  = xc_v;
            end else begin
                sel_kind = SRC_RF;
                sel_val  = rf_in;
            end
        end

        assign op_val[o*DW +: DW] = sel_val;
        assign op_kind[o*2 +: 2]  = sel_kind;

        AST_ZERO_NO_FWD: assert property (@(posedge clk) disable iff (rst)
            (op_src[o*AW +: AW] == '0) |-> (op_kind[o*2 +: 2] == SRC_RF)); // R2

        AST_RF_PASS: assert property (@(posedge clk) disable iff (rst)
            (op_kind[o*2 +: 2] == SRC_RF) |-> (op_val[o*DW +: DW] == rf_val[o*DW +: DW])); // R5

        AST_MX_FIRST: assert property (@(posedge clk) disable iff (rst)
            mx_hit |-> (op_kind[o*2 +: 2] == SRC_MX)); // R3

        AST_LOCAL_OVER_REMOTE: assert property (@(posedge clk) disable iff (rst)
            (op_kind[o*2 +: 2] == SRC_XC) |-> (!mx_hit && !wx_hit)); // R8
    end
endmodule

// File: tb/opnd_bypass_net_bench.sv
module opnd_bypass_net_bench;
    localparam int LANES = 4;
    localparam int OPS   = 2 * LANES;
    localparam int DW    = 32;
    localparam int AW    = 5;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [OPS*AW-1:0]     op_src;
    logic [OPS*DW-1:0]     rf_val;
    logic [LANES-1:0]      ex_vld, ex_wen, wb_vld, wb_wen;
    logic [LANES*AW-1:0]   ex_dst, wb_dst;
    logic [LANES*DW-1:0]   ex_res, wb_res;
    logic [OPS*DW-1:0]     op_val, fl_val;
    logic [OPS*2-1:0]      op_kind, fl_kind;

    int checks   = 0;
    int failures = 0;

    always #5 clk = ~clk;

    opnd_bypass_net #(.LANES(LANES), .CLUSTERS(2), .XDELAY(2), .DW(DW), .AW(AW)) u_opnd_bypass_net (
        .clk, .rst, .op_src, .rf_val, .ex_vld, .ex_wen, .ex_dst, .ex_res,
        .wb_vld, .wb_wen, .wb_dst, .wb_res, .op_val, .op_kind
    );

    opnd_bypass_net #(.LANES(LANES), .CLUSTERS(1), .XDELAY(1), .DW(DW), .AW(AW)) u_opnd_bypass_net_flat (
        .clk, .rst, .op_src, .rf_val, .ex_vld, .ex_wen, .ex_dst, .ex_res,
        .wb_vld, .wb_wen, .wb_dst, .wb_res, .op_val(fl_val), .op_kind(fl_kind)
    );

    function automatic logic [DW-1:0] rf_of(input int o);
        return 32'hF000_0000 + o;
    endfunction

    task automatic clear_all();
        ex_vld = '0; ex_wen = '0; ex_dst = '0; ex_res = '0;
        wb_vld = '0; wb_wen = '0; wb_dst = '0; wb_res = '0;
        for (int o = 0; o < OPS; o++) begin
            op_src[o*AW +: AW] = 5'd31;
            rf_val[o*DW +: DW] = rf_of(o);
        end
    endtask

    task automatic set_ex(input int l, input logic v, input logic w, input logic [AW-1:0] d, input logic [DW-1:0] r);
        ex_vld[l] = v; ex_wen[l] = w; ex_dst[l*AW +: AW] = d; ex_res[l*DW +: DW] = r;
    endtask

    task automatic set_wb(input int l, input logic v, input logic w, input logic [AW-1:0] d, input logic [DW-1:0] r);
        wb_vld[l] = v; wb_wen[l] = w; wb_dst[l*AW +: AW] = d; wb_res[l*DW +: DW] = r;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic chk(input string rq, input bit flat, input int o,
                       input logic [1:0] ek, input logic [DW-1:0] ev);
        logic [1:0]    ak;
        logic [DW-1:0] av;
        ak = flat ? fl_kind[o*2 +: 2] : op_kind[o*2 +: 2];
        av = flat ? fl_val[o*DW +: DW] : op_val[o*DW +: DW];
        checks++;
        if (ak !== ek || av !== ev) begin
            failures++;
            $display("FAIL %s %s op%0d: kind=%0d val=%h expected kind=%0d val=%h",
                     rq, flat ? "flat" : "clustered", o, ak, av, ek, ev);
        end
    endtask

    task automatic flush();
        clear_all();
        tick(); tick(); tick();
    endtask

    // R1 R5: empty after reset, nothing matches
    task automatic t_reset();
        clear_all();
        for (int o = 0; o < OPS; o++) op_src[o*AW +: AW] = 5'd7;
        settle();
        for (int o = 0; o < OPS; o++) chk("R1", 0, o, 2'd0, rf_of(o));
        chk("R5", 1, 3, 2'd0, rf_of(3));
        flush();
    endtask

    // R2: match qualification
    task automatic t_match();
        clear_all();
        op_src[0 +: AW] = 5'd7;
        set_ex(0, 1'b0, 1'b1, 5'd7, 32'h1111_0001);
        settle(); chk("R2", 0, 0, 2'd0, rf_of(0));
        set_ex(0, 1'b1, 1'b0, 5'd7, 32'h1111_0002);
        settle(); chk("R2", 0, 0, 2'd0, rf_of(0));
        op_src[0 +: AW] = 5'd0;
        set_ex(0, 1'b1, 1'b1, 5'd0, 32'h1111_0003);
        settle(); chk("R2", 0, 0, 2'd0, rf_of(0));
        chk("R2", 1, 0, 2'd0, rf_of(0));
        op_src[0 +: AW] = 5'd7;
        op_src[1*AW +: AW] = 5'd8;
        set_ex(0, 1'b1, 1'b1, 5'd7, 32'h1111_0004);
        settle();
        chk("R2", 0, 0, 2'd1, 32'h1111_0004);
        chk("R2", 0, 1, 2'd0, rf_of(1));
        flush();
    endtask

    // R3: execute level beats writeback level
    task automatic t_level_prio();
        clear_all();
        op_src[0 +: AW] = 5'd5;
        set_ex(1, 1'b1, 1'b1, 5'd5, 32'hAAAA_0001);
        set_wb(0, 1'b1, 1'b1, 5'd5, 32'hBBBB_0001);
        settle();
        chk("R3", 0, 0, 2'd1, 32'hAAAA_0001);
        chk("R3", 1, 0, 2'd1, 32'hAAAA_0001);
        set_ex(1, 1'b0, 1'b0, 5'd0, 32'h0);
        settle();
        chk("R3", 0, 0, 2'd2, 32'hBBBB_0001);
        flush();
    endtask

    // R4: youngest lane wins inside a level
    task automatic t_youngest();
        clear_all();
        op_src[0 +: AW] = 5'd9;
        op_src[4*AW +: AW] = 5'd9;
        set_ex(0, 1'b1, 1'b1, 5'd9, 32'hC000_0000);
        set_ex(1, 1'b1, 1'b1, 5'd9, 32'hC000_0001);
        set_ex(2, 1'b1, 1'b1, 5'd9, 32'hC000_0002);
        set_ex(3, 1'b1, 1'b1, 5'd9, 32'hC000_0003);
        settle();
        chk("R4", 0, 0, 2'd1, 32'hC000_0001);
        chk("R4", 0, 4, 2'd1, 32'hC000_0003);
        chk("R4", 1, 0, 2'd1, 32'hC000_0003);
        clear_all();
        op_src[0 +: AW] = 5'd9;
        set_wb(0, 1'b1, 1'b1, 5'd9, 32'hD000_0000);
        set_wb(1, 1'b1, 1'b1, 5'd9, 32'hD000_0001);
        settle();
        chk("R4", 0, 0, 2'd2, 32'hD000_0001);
        flush();
    endtask

    // R6 R10 R7: group locality and remote delay window
    task automatic t_remote_window();
        clear_all();
        op_src[0 +: AW] = 5'd6;
        set_ex(3, 1'b1, 1'b1, 5'd6, 32'hE000_0003);
        settle();
        chk("R6", 0, 0, 2'd0, rf_of(0));
        chk("R10", 1, 0, 2'd1, 32'hE000_0003);
        chk("R6", 0, 6, 2'd0, rf_of(6));
        tick();
        set_ex(3, 1'b0, 1'b0, 5'd0, 32'h0);
        settle();
        chk("R7", 0, 0, 2'd0, rf_of(0));
        tick(); settle();
        chk("R7", 0, 0, 2'd3, 32'hE000_0003);
        chk("R7", 1, 0, 2'd0, rf_of(0));
        tick(); settle();
        chk("R7", 0, 0, 2'd0, rf_of(0));
        flush();
    endtask

    // R8: local forward over remote value in the same cycle
    task automatic t_local_vs_remote();
        clear_all();
        op_src[0 +: AW] = 5'd6;
        set_ex(2, 1'b1, 1'b1, 5'd6, 32'h5E00_0002);
        tick();
        set_ex(2, 1'b0, 1'b0, 5'd0, 32'h0);
        tick();
        set_wb(0, 1'b1, 1'b1, 5'd6, 32'h10CA_0000);
        settle();
        chk("R8", 0, 0, 2'd2, 32'h10CA_0000);
        set_wb(0, 1'b0, 1'b0, 5'd0, 32'h0);
        settle();
        chk("R8", 0, 0, 2'd3, 32'h5E00_0002);
        flush();
    endtask

    // R9: youngest remote wins, write-disabled remote ignored
    task automatic t_remote_young();
        clear_all();
        op_src[0 +: AW] = 5'd4;
        op_src[2*AW +: AW] = 5'd12;
        set_ex(2, 1'b1, 1'b1, 5'd4, 32'h4400_0002);
        set_ex(3, 1'b1, 1'b1, 5'd4, 32'h4400_0003);
        tick();
        clear_all();
        op_src[0 +: AW] = 5'd4;
        op_src[2*AW +: AW] = 5'd12;
        set_ex(3, 1'b1, 1'b0, 5'd12, 32'h4400_0033);
        tick(); settle();
        chk("R9", 0, 0, 2'd3, 32'h4400_0003);
        set_ex(3, 1'b0, 1'b0, 5'd0, 32'h0);
        tick(); settle();
        chk("R9", 0, 2, 2'd0, rf_of(2));
        flush();
    endtask

    bit done = 1'b0;

    initial begin
        clear_all();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_match();
        t_level_prio();
        t_youngest();
        t_remote_window();
        t_local_vs_remote();
        t_remote_young();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule